// File: doc/BRIEF.md
# HEC Cell Aligner

This block takes a continuous byte stream that carries fixed-length ATM cells with no alignment to the stream. It finds where each 53-byte cell begins by using the header check byte, which is a CRC-8 over the four header bytes. The block then hands the bytes on, aligned to cells, with a cell-valid flag and a start-of-cell flag. It also reports which of its three alignment states it is in.

While the block is searching, it forms a candidate header from the last four accepted bytes at every byte position. It checks the byte now arriving against the CRC of that candidate. After a match it holds that phase. From then on it checks only the byte that falls every 53 bytes at the check position. Hysteresis decides when the alignment is trusted and when it is given up:
- A run of correct checks makes the alignment trusted.
- A run of failed checks gives it up.

Payload descrambling, header error correction and idle-cell removal are handled by the surrounding logic.

Top module: `hec_cell_aligner`

## Requirements
- R1: After reset, `align_state` is 0 (searching), and `cell_valid` and `cell_start` are both low.
- R2: The header check runs the four header bytes through a CRC-8 with polynomial x^8+x^2+x+1 (0x07). The CRC starts at zero, takes the first received byte first, and takes each byte most significant bit first. The result is XORed with 0x55 and compared with the fifth byte. A fifth byte equal to the CRC without the 0x55 XOR is a mismatch.
- R3: In the searching state (code 0), the block tests every accepted byte, once at least four bytes have been accepted since reset. If the byte matches the CRC of the four bytes before it, the block locks the cell phase at that byte and moves to the provisional state (code 1). `align_state` shows the new code in the cycle after that byte.
- R4: In the provisional state, one failed check at a header position returns the block to the searching state.
- R5: The provisional state becomes the synchronized state (code 2) on the sixth consecutive correct check after the lock, and not earlier.
- R6: In the synchronized state, the seventh consecutive failed check returns the block to the searching state. A correct check clears the count of failures.
- R7: While synchronized, each accepted byte is presented on `cell_byte` with `cell_valid` high in the following cycle. The byte presented is the one accepted four bytes earlier. `cell_start` is high exactly when the presented byte is the first header byte. The cell whose check completes synchronization is the first one presented.
- R8: A cycle with `in_valid` low changes no state and presents no byte: `cell_valid` and `cell_start` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Unaligned stream byte |
| cell_byte | output | 8 | Cell-aligned byte |
| cell_valid | output | 1 | `cell_byte` holds a byte of a synchronized cell |
| cell_start | output | 1 | `cell_byte` is the first header byte of a cell |
| align_state | output | 2 | 0 searching, 1 provisional, 2 synchronized |

## Verification
The hardest situation to reach from the ports is the failure counter in the synchronized state being cleared partway through a run of bad headers. Reaching it requires an exact count of corrupted check bytes placed at the 53-byte phase the block has locked to. The stimulus does this as follows:
- It builds whole cells in the bench, each with a correct or deliberately corrupted check byte.
- It sends six bad cells, one good cell, then six more bad cells, and confirms the block is still synchronized.
- A single further bad cell must drop it to searching.

Locking onto a phase that is not a cell boundary, inside a payload of random bytes, is left to the per-cycle reference model.

// File: rtl/hec_align_pkg.sv
package hec_align_pkg;

   typedef enum logic [1:0] {
      ST_HUNT    = 2'd0,
      ST_PRESYNC = 2'd1,
      ST_SYNC    = 2'd2
   } align_state_e;

   // One byte of a most-significant-bit-first CRC-8 with the given polynomial.
   function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                            input logic [7:0] data,
                                            input logic [7:0] poly);
      logic [7:0] c;
      logic       fb;
      c = crc;
      for (int i = 7; i >= 0; i--) begin
         fb = c[7] ^ data[i];
         c  = {c[6:0], 1'b0} ^ (fb ? poly : 8'h00);
      end
      return c;
   endfunction

endpackage

// File: rtl/hec_crc8.sv
module hec_crc8 #(
   parameter int         HDR_LEN = 4,
   parameter logic [7:0] POLY    = 8'h07,
   parameter logic [7:0] COSET   = 8'h55
) (
   input  logic [HDR_LEN*8-1:0] hdr_flat,
   output logic [7:0]           hec
);
   import hec_align_pkg::*;

   logic [7:0] stage [0:HDR_LEN];

   assign stage[0] = 8'h00;

   generate
      for (genvar g = 0; g < HDR_LEN; g++) begin : g_byte
         assign stage[g+1] = crc8_step(stage[g],
                                       hdr_flat[(HDR_LEN-1-g)*8 +: 8], POLY);
      end
   endgenerate

   assign hec = stage[HDR_LEN] ^ COSET;

endmodule

// File: rtl/hec_window.sv
module hec_window #(
   parameter int HDR_LEN = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 shift_en,
   input  logic [7:0]           din,
   output logic [HDR_LEN*8-1:0] win_flat,
   output logic [7:0]           oldest,
   output logic                 full
);
   localparam int FILL_W = $clog2(HDR_LEN + 1);

   logic [7:0]        win [0:HDR_LEN-1];
   logic [FILL_W-1:0] fill;

   generate
      for (genvar i = 0; i < HDR_LEN; i++) begin : g_tap
         if (i == HDR_LEN - 1) begin : g_last
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n)        win[i] <= 8'h00;
               else if (shift_en) win[i] <= din;
         end else begin : g_mid
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n)        win[i] <= 8'h00;
               else if (shift_en) win[i] <= win[i+1];
         end
         assign win_flat[(HDR_LEN-1-i)*8 +: 8] = win[i];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         fill <= '0;
      else if (shift_en && fill != FILL_W'(HDR_LEN))
         fill <= fill + FILL_W'(1);

   assign full   = (fill == FILL_W'(HDR_LEN));
   assign oldest = win[0];

endmodule

// File: rtl/hec_lock_fsm.sv
module hec_lock_fsm
   import hec_align_pkg::*;
#(
   parameter int CELL_LEN   = 53,
   parameter int HDR_LEN    = 4,
   parameter int PRESYNC_N  = 6,
   parameter int SYNC_BAD_N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         hit,
   output align_state_e state,
   output align_state_e state_nxt,
   output logic         at_header
);
   localparam int POS_W  = $clog2(CELL_LEN);
   localparam int GOOD_W = $clog2(PRESYNC_N + 1);
   localparam int BAD_W  = $clog2(SYNC_BAD_N + 1);
   localparam logic [POS_W-1:0] HEC_POS  = POS_W'(HDR_LEN);
   localparam logic [POS_W-1:0] LAST_POS = POS_W'(CELL_LEN - 1);

   logic [POS_W-1:0]  pos, pos_nxt, pos_inc;
   logic [GOOD_W-1:0] good, good_nxt;
   logic [BAD_W-1:0]  bad, bad_nxt;
   logic              chk_slot;

   assign pos_inc  = (pos == LAST_POS) ? '0 : pos + POS_W'(1);
   assign chk_slot = in_valid && (state != ST_HUNT) && (pos_inc == HEC_POS);

   always_comb begin
      state_nxt = state;
      pos_nxt   = pos;
      good_nxt  = good;
      bad_nxt   = bad;
      if (in_valid) begin
         unique case (state)
            ST_HUNT: begin
               if (hit) begin
                  state_nxt = ST_PRESYNC;
                  pos_nxt   = HEC_POS;
                  good_nxt  = '0;
               end
            end
            ST_PRESYNC: begin
               pos_nxt = pos_inc;
               if (chk_slot) begin
                  if (!hit) begin
                     state_nxt = ST_HUNT;
                  end else if (good == GOOD_W'(PRESYNC_N - 1)) begin
                     state_nxt = ST_SYNC;
                     bad_nxt   = '0;
                  end else begin
                     good_nxt = good + GOOD_W'(1);
                  end
               end
            end
            default: begin
               pos_nxt = pos_inc;
               if (chk_slot) begin
                  if (hit)
                     bad_nxt = '0;
                  else if (bad == BAD_W'(SYNC_BAD_N - 1))
                     state_nxt = ST_HUNT;
                  else
                     bad_nxt = bad + BAD_W'(1);
               end
            end
         endcase
      end
   end

   assign at_header = in_valid && (pos_nxt == HEC_POS);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         state <= ST_HUNT;
         pos   <= '0;
         good  <= '0;
         bad   <= '0;
      end else begin
         state <= state_nxt;
         pos   <= pos_nxt;
         good  <= good_nxt;
         bad   <= bad_nxt;
      end

   // R3
   hunt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HUNT && in_valid && hit) |=> state == ST_PRESYNC);

   // R4
   presync_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PRESYNC && chk_slot && !hit) |=> state == ST_HUNT);

   // R5
   no_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_HUNT |=> state != ST_SYNC);

   // R6
   sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SYNC && chk_slot && hit) |=> state == ST_SYNC);

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(state));

endmodule

// File: rtl/hec_cell_aligner.sv
module hec_cell_aligner #(
   parameter int         CELL_LEN   = 53,
   parameter int         HDR_LEN    = 4,
   parameter int         PRESYNC_N  = 6,
   parameter int         SYNC_BAD_N = 7,
   parameter logic [7:0] POLY       = 8'h07,
   parameter logic [7:0] COSET      = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic [7:0] in_byte,
   output logic [7:0] cell_byte,
   output logic       cell_valid,
   output logic       cell_start,
   output logic [1:0] align_state
);
   import hec_align_pkg::*;

   generate
      if (CELL_LEN <= HDR_LEN + 1) begin : g_bad_len
         $error("CELL_LEN must exceed HDR_LEN + 1");
      end
      if (HDR_LEN < 1) begin : g_bad_hdr
         $error("HDR_LEN must be at least 1");
      end
      if (PRESYNC_N < 1 || SYNC_BAD_N < 1) begin : g_bad_cnt
         $error("hysteresis counts must be at least 1");
      end
   endgenerate

   logic [HDR_LEN*8-1:0] win_flat;
   logic [7:0]           oldest, hec_calc;
   logic                 full, hit, at_header;
   align_state_e         state, state_nxt;

   hec_window #(.HDR_LEN(HDR_LEN)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .din      (in_byte),
      .win_flat (win_flat),
      .oldest   (oldest),
      .full     (full)
   );

   hec_crc8 #(.HDR_LEN(HDR_LEN), .POLY(POLY), .COSET(COSET)) u_crc (
      .hdr_flat (win_flat),
      .hec      (hec_calc)
   );

   assign hit = full && (hec_calc == in_byte);

   hec_lock_fsm #(
      .CELL_LEN   (CELL_LEN),
      .HDR_LEN    (HDR_LEN),
      .PRESYNC_N  (PRESYNC_N),
      .SYNC_BAD_N (SYNC_BAD_N)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .hit       (hit),
      .state     (state),
      .state_nxt (state_nxt),
      .at_header (at_header)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cell_byte  <= 8'h00;
         cell_valid <= 1'b0;
         cell_start <= 1'b0;
      end else begin
         cell_valid <= in_valid && (state_nxt == ST_SYNC);
         cell_start <= at_header && (state_nxt == ST_SYNC);
         if (in_valid)
            cell_byte <= oldest;
      end

   assign align_state = state;

   // R7
   start_in_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cell_start |-> cell_valid);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !cell_valid);

endmodule

// File: tb/sim_hec_cell_aligner.sv
`timescale 1ns/1ps
module sim_hec_cell_aligner;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic [7:0] in_byte;
   logic [7:0] cell_byte;
   logic       cell_valid;
   logic       cell_start;
   logic [1:0] align_state;

   always #2 clk = ~clk;

   hec_cell_aligner u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_byte     (in_byte),
      .cell_byte   (cell_byte),
      .cell_valid  (cell_valid),
      .cell_start  (cell_start),
      .align_state (align_state)
   );

   int checks = 0;
   int fails  = 0;

   // reference model
   int       m_state, m_pos, m_good, m_bad;
   byte      hist[$];
   bit       e_valid, e_start;
   bit [7:0] e_data;

   // captured right after the check byte of the last cell sent
   int       cap_state;
   bit       cap_start;
   bit [7:0] cap_data;

   function automatic bit [7:0] raw_crc(input bit [31:0] h);
      bit [39:0] v;
      v = {h, 8'h00};
      for (int i = 39; i >= 8; i--)
         if (v[i]) v = v ^ (40'h107 << (i - 8));
      return v[7:0];
   endfunction

   function automatic bit [7:0] ref_hec(input bit [31:0] h);
      return raw_crc(h) ^ 8'h55;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_state = 0; m_pos = 0; m_good = 0; m_bad = 0;
      hist.delete();
      e_valid = 0; e_start = 0; e_data = 0;
   endtask

   task automatic model_step(input bit [7:0] b);
      bit       hit;
      bit [7:0] old;
      int       np;
      hit = 0;
      old = 0;
      if (hist.size() == 4) begin
         hit = (ref_hec({hist[0], hist[1], hist[2], hist[3]}) == b);
         old = hist[0];
      end
      np = (m_pos == 52) ? 0 : m_pos + 1;
      if (m_state == 0) begin
         if (hit) begin m_state = 1; m_pos = 4; m_good = 0; end
      end else if (m_state == 1) begin
         m_pos = np;
         if (m_pos == 4) begin
            if (!hit) m_state = 0;
            else begin
               m_good++;
               if (m_good == 6) begin m_state = 2; m_bad = 0; end
            end
         end
      end else begin
         m_pos = np;
         if (m_pos == 4) begin
            if (hit) m_bad = 0;
            else begin
               m_bad++;
               if (m_bad == 7) m_state = 0;
            end
         end
      end
      e_valid = (m_state == 2);
      e_start = e_valid && (m_pos == 4);
      e_data  = old;
      hist.push_back(b);
      if (hist.size() > 4) void'(hist.pop_front());
   endtask

   task automatic compare();
      check(align_state == 2'(m_state), "R3/R4/R5/R6", "align_state",
            align_state, m_state);
      check(cell_valid == e_valid, "R7/R8", "cell_valid", cell_valid, e_valid);
      check(cell_start == e_start, "R7", "cell_start", cell_start, e_start);
      if (e_valid)
         check(cell_byte == e_data, "R7", "cell_byte", cell_byte, e_data);
   endtask

   task automatic step(input bit v, input bit [7:0] b);
      @(negedge clk);
      in_valid = v;
      in_byte  = b;
      @(posedge clk);
      if (v) model_step(b);
      else begin e_valid = 0; e_start = 0; end
      #1;
      compare();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_byte  = 8'h00;
      model_reset();
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // mode 0: correct check byte, 1: corrupted, 2: CRC without the 0x55 XOR
   task automatic send_cell(input bit [31:0] h, input int mode, input bit gaps);
      bit [7:0] hec;
      hec = ref_hec(h);
      if (mode == 1) hec = hec ^ 8'h01;
      if (mode == 2) hec = raw_crc(h);
      for (int k = 0; k < 53; k++) begin
         bit [7:0] b;
         if (k < 4)       b = h[31 - 8*k -: 8];
         else if (k == 4) b = hec;
         else             b = 8'($urandom);
         step(1'b1, b);
         if (k == 4) begin
            cap_state = align_state;
            cap_start = cell_start;
            cap_data  = cell_byte;
         end
         if (gaps && (k % 3 == 0)) begin
            step(1'b0, 8'hEE);
            check(cell_valid == 1'b0, "R8", "cell_valid in idle", cell_valid, 0);
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_byte  = 8'h00;
      model_reset();
      do_reset();
      #1;
      // R1 reset state
      check(align_state == 2'd0, "R1", "align_state after reset", align_state, 0);
      check(cell_valid == 1'b0, "R1", "cell_valid after reset", cell_valid, 0);
      check(cell_start == 1'b0, "R1", "cell_start after reset", cell_start, 0);

      // R3 lock on the first correct header
      send_cell(32'h0A1B2C3D, 0, 1'b0);
      check(cap_state == 1, "R3", "state after first header", cap_state, 1);

      // R5 five more correct: still provisional, sixth: synchronized
      for (int c = 0; c < 5; c++) send_cell(32'h00100200 + c, 0, 1'b0);
      check(cap_state == 1, "R5", "state after five in provisional", cap_state, 1);
      send_cell(32'h4F3E2D1C, 0, 1'b0);
      check(cap_state == 2, "R5", "state after sixth in provisional", cap_state, 2);
      // R7 first header byte presented with start flag
      check(cap_start == 1'b1, "R7", "cell_start on sync cell", cap_start, 1);
      check(cap_data == 8'h4F, "R7", "first header byte", cap_data, 8'h4F);

      // R8 idle cycles inside synchronized cells
      send_cell(32'h12345678, 0, 1'b1);
      send_cell(32'h9ABCDEF0, 0, 1'b1);
      check(align_state == 2'd2, "R8", "state after gapped cells", align_state, 2);

      // R6 six bad, a good clears, six bad, then the seventh drops
      for (int c = 0; c < 6; c++) send_cell(32'h11110000 + c, 1, 1'b0);
      check(cap_state == 2, "R6", "state after six bad", cap_state, 2);
      send_cell(32'h22222222, 0, 1'b0);
      for (int c = 0; c < 6; c++) send_cell(32'h33330000 + c, 1, 1'b0);
      check(cap_state == 2, "R6", "count cleared by good header", cap_state, 2);
      send_cell(32'h44444444, 1, 1'b0);
      check(cap_state == 0, "R6", "state after seventh bad", cap_state, 0);

      // R3 search from an arbitrary phase, model-tracked
      for (int k = 0; k < 11; k++) step(1'b1, 8'($urandom));
      for (int c = 0; c < 10; c++) send_cell($urandom, 0, 1'b0);

      // R2 check byte without the coset XOR does not lock
      do_reset();
      send_cell(32'h5A5A0F0F, 2, 1'b0);
      check(cap_state == 0, "R2", "no lock without coset", cap_state, 0);

      // R4 single error in provisional returns to search
      do_reset();
      send_cell(32'h76543210, 0, 1'b0);
      check(cap_state == 1, "R2", "lock with coset", cap_state, 1);
      send_cell(32'h01020304, 1, 1'b0);
      check(cap_state == 0, "R4", "state after provisional error", cap_state, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule